// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This block sits between a processor core and a 32-bit data memory that has one write enable per byte. It receives the kind of access the current instruction makes, the byte address that instruction computed, the register value to be stored and the word the memory currently returns. From these it forms everything the memory port and the write-back path need. It produces the word index to present to the memory, the per-byte write enables and the overall write enable. It produces the write data with the store byte placed on every lane. It also produces the value to be written back for a load.

Two load widths are handled: a full word, and a single byte chosen by the two low address bits and zero-extended. Two store widths are handled: a full word, and a single byte that enables only its own lane. Word accesses are assumed aligned. The block is purely combinational. The memory on the other side samples the enables and data on its rising clock edge and returns read data without a clock. Its read enable can therefore stay permanently on and is not driven by this block.

Top module: `byte_lane_lsu`

## Requirements
- R1: `word_addr` always equals `byte_addr` shifted right by two, for every access kind.
- R2: Access kinds are coded on `acc_kind` as none=0, word load=1, byte load=2, word store=3, byte store=4. Codes 5 to 7 act as none. `mem_we` is 1 exactly when the code is 3 or 4.
- R3: For a word store, `lane_we` is 4'b1111 and `wr_data` equals `st_data`, whatever `byte_addr[1:0]` holds.
- R4: For a byte store, `lane_we` has exactly one bit set, at position `byte_addr[1:0]`. The lanes are little-endian: offset 0 is bit 0 and data bits [7:0], and offset 3 is bit 3 and data bits [31:24].
- R5: For a byte store, `wr_data` carries `st_data[7:0]` on all four lanes.
- R6: When `mem_we` is 0, `lane_we` is 0 and `wr_data` is 0.
- R7: For a word load, `ld_result` equals `rd_word`, whatever `byte_addr[1:0]` holds.
- R8: For a byte load, `ld_result` is the byte `rd_word[8*k+7:8*k]` with k = `byte_addr[1:0]`, and bits [31:8] are 0.
- R9: For every code that is not a load (0, 3, 4, 5, 6, 7), `ld_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_kind | input | 3 | Access kind code of the current instruction |
| byte_addr | input | 32 | Byte address computed by the core |
| st_data | input | 32 | Register value to be stored |
| rd_word | input | 32 | Word read from the data memory |
| word_addr | output | 30 | Word index presented to the memory |
| lane_we | output | 4 | Per-byte write enables, bit k for lane k |
| wr_data | output | 32 | Lane-placed write data |
| mem_we | output | 1 | Memory write enable |
| ld_result | output | 32 | Value written back for a load |

## Verification
The hardest cases to reach from the ports are those where the offset and the access width disagree. A word access can arrive with nonzero low address bits that must be ignored. The undefined kind codes 5 to 7 must also write and load nothing. The vector table pairs a word load at offset 3 with the same read word used for the byte loads, so an offset leaking into the word path shows up as a mismatch. A directed sweep then drives all eight codes at all four offsets and checks both the enable outputs and the load result for each pair.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [2:0] {
    ACC_NONE = 3'd0,
    ACC_LW   = 3'd1,
    ACC_LBU  = 3'd2,
    ACC_SW   = 3'd3,
    ACC_SB   = 3'd4
  } acc_kind_e;

  localparam int KIND_W = 3;

endpackage

// File: rtl/lsu_lane_decode.sv
module lsu_lane_decode #(
  parameter int NUM_LANES = 4,
  localparam int OFS_W = $clog2(NUM_LANES)
) (
  input  logic [OFS_W-1:0]     ofs,
  output logic [NUM_LANES-1:0] lane_oh
);

  // One comparator per lane; exactly one lane matches any offset.
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_oh[g] = (ofs == OFS_W'(g));
  end

endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack #(
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 4,
  localparam int DATA_W = LANE_W * NUM_LANES
) (
  input  logic                 do_word,
  input  logic                 do_byte,
  input  logic [NUM_LANES-1:0] lane_oh,
  input  logic [DATA_W-1:0]    st_data,
  output logic [NUM_LANES-1:0] lane_we,
  output logic [DATA_W-1:0]    wr_data
);

  function automatic logic [DATA_W-1:0] spread_low_lane(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < NUM_LANES; i++) r[i*LANE_W +: LANE_W] = v[LANE_W-1:0];
    return r;
  endfunction

  logic [DATA_W-1:0] spread;
  assign spread = spread_low_lane(st_data);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_we[g] = do_word | (do_byte & lane_oh[g]);
    assign wr_data[g*LANE_W +: LANE_W] =
      do_word ? st_data[g*LANE_W +: LANE_W] :
      do_byte ? spread[g*LANE_W +: LANE_W]  : '0;
  end

endmodule

// File: rtl/lsu_load_unpack.sv
module lsu_load_unpack #(
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 4,
  localparam int DATA_W = LANE_W * NUM_LANES
) (
  input  logic                 do_word,
  input  logic                 do_byte,
  input  logic [NUM_LANES-1:0] lane_oh,
  input  logic [DATA_W-1:0]    rd_word,
  output logic [DATA_W-1:0]    ld_result
);

  // AND-OR lane picker driven by the one-hot lane select.
  function automatic logic [LANE_W-1:0] pick_lane(input logic [DATA_W-1:0] w,
                                                  input logic [NUM_LANES-1:0] oh);
    logic [LANE_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_LANES; i++)
      if (oh[i]) r = r | w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  logic [LANE_W-1:0] picked;
  assign picked = pick_lane(rd_word, lane_oh);

  always_comb begin
    if (do_word)      ld_result = rd_word;
    else if (do_byte) ld_result = {{(DATA_W-LANE_W){1'b0}}, picked};
    else              ld_result = '0;
  end

endmodule

// File: rtl/byte_lane_lsu.sv
module byte_lane_lsu #(
  parameter int ADDR_W    = 32,
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 4,
  localparam int DATA_W  = LANE_W * NUM_LANES,
  localparam int OFS_W   = $clog2(NUM_LANES),
  localparam int WADDR_W = ADDR_W - OFS_W
) (
  input  logic [2:0]           acc_kind,
  input  logic [ADDR_W-1:0]    byte_addr,
  input  logic [DATA_W-1:0]    st_data,
  input  logic [DATA_W-1:0]    rd_word,
  output logic [WADDR_W-1:0]   word_addr,
  output logic [NUM_LANES-1:0] lane_we,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 mem_we,
  output logic [DATA_W-1:0]    ld_result
);
  import lsu_align_pkg::*;

  // Named decode events, also observed by the bound checker.
  logic                 is_lw, is_lbu, is_sw, is_sb, is_store;
  logic [OFS_W-1:0]     ofs;
  logic [NUM_LANES-1:0] lane_oh;

  assign is_lw    = (acc_kind == ACC_LW);
  assign is_lbu   = (acc_kind == ACC_LBU);
  assign is_sw    = (acc_kind == ACC_SW);
  assign is_sb    = (acc_kind == ACC_SB);
  assign is_store = is_sw | is_sb;
  assign ofs      = byte_addr[OFS_W-1:0];

  assign word_addr = byte_addr[ADDR_W-1:OFS_W];
  assign mem_we    = is_store;

  lsu_lane_decode #(.NUM_LANES(NUM_LANES)) u_dec (
    .ofs     (ofs),
    .lane_oh (lane_oh)
  );

  lsu_store_pack #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_st (
    .do_word (is_sw),
    .do_byte (is_sb),
    .lane_oh (lane_oh),
    .st_data (st_data),
    .lane_we (lane_we),
    .wr_data (wr_data)
  );

  lsu_load_unpack #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_ld (
    .do_word   (is_lw),
    .do_byte   (is_lbu),
    .lane_oh   (lane_oh),
    .rd_word   (rd_word),
    .ld_result (ld_result)
  );

endmodule

// File: rtl/byte_lane_lsu_chk.sv
module byte_lane_lsu_chk #(
  parameter int ADDR_W    = 32,
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 4,
  localparam int DATA_W  = LANE_W * NUM_LANES,
  localparam int OFS_W   = $clog2(NUM_LANES),
  localparam int WADDR_W = ADDR_W - OFS_W
) (
  input logic [2:0]           acc_kind,
  input logic [ADDR_W-1:0]    byte_addr,
  input logic [DATA_W-1:0]    st_data,
  input logic [DATA_W-1:0]    rd_word,
  input logic [WADDR_W-1:0]   word_addr,
  input logic [NUM_LANES-1:0] lane_we,
  input logic [DATA_W-1:0]    wr_data,
  input logic                 mem_we,
  input logic [DATA_W-1:0]    ld_result,
  input logic [NUM_LANES-1:0] lane_oh
);

  logic [ADDR_W-1:0] rebuilt;
  assign rebuilt = {word_addr, {OFS_W{1'b0}}};

  always_comb begin
    // R1: the word index times four is the address with its offset cleared
    a_r1_word_index: assert (rebuilt == (byte_addr & ~ADDR_W'(NUM_LANES - 1)));
    // R2
    a_r2_we_only_store: assert (mem_we == (acc_kind == 3'd3 || acc_kind == 3'd4));
    // decoder always selects a single lane
    a_r4_lane_onehot: assert ($countones(lane_oh) == 1);
    if (acc_kind == 3'd3) begin
      a_r3_full_word: assert (&lane_we && wr_data == st_data);
    end
    if (acc_kind == 3'd4) begin
      a_r4_single_lane: assert ($countones(lane_we) == 1 && lane_we[byte_addr[OFS_W-1:0]]);
      a_r5_low_byte: assert (wr_data[LANE_W-1:0] == st_data[LANE_W-1:0]);
    end
    if (!mem_we) begin
      a_r6_quiet_idle: assert (lane_we == '0 && wr_data == '0);
    end
    if (acc_kind == 3'd1) begin
      a_r7_word_load: assert (ld_result == rd_word);
    end
    if (acc_kind == 3'd2) begin
      a_r8_zero_ext: assert (ld_result[DATA_W-1:LANE_W] == '0);
    end
    if (acc_kind != 3'd1 && acc_kind != 3'd2) begin
      a_r9_no_load: assert (ld_result == '0);
    end
  end

endmodule

bind byte_lane_lsu byte_lane_lsu_chk #(
  .ADDR_W(ADDR_W), .LANE_W(LANE_W), .NUM_LANES(NUM_LANES)
) u_chk (
  .acc_kind  (acc_kind),
  .byte_addr (byte_addr),
  .st_data   (st_data),
  .rd_word   (rd_word),
  .word_addr (word_addr),
  .lane_we   (lane_we),
  .wr_data   (wr_data),
  .mem_we    (mem_we),
  .ld_result (ld_result),
  .lane_oh   (lane_oh)
);

// File: tb/byte_lane_lsu_tb.sv
module byte_lane_lsu_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [2:0]  acc_kind;
  logic [31:0] byte_addr, st_data, rd_word, wr_data, ld_result;
  logic [29:0] word_addr;
  logic [3:0]  lane_we;
  logic        mem_we;

  byte_lane_lsu u_dut (
    .acc_kind(acc_kind), .byte_addr(byte_addr), .st_data(st_data), .rd_word(rd_word),
    .word_addr(word_addr), .lane_we(lane_we), .wr_data(wr_data), .mem_we(mem_we),
    .ld_result(ld_result)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  kind;
    logic [31:0] addr;
    logic [31:0] sd;
    logic [31:0] rd;
    logic        we;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] ld;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{3'd1, 32'h0000_0100, 32'h1122_3344, 32'hA1B2_C3D4, 1'b0, 4'h0, 32'h0, 32'hA1B2_C3D4},
    '{3'd2, 32'h0000_0100, 32'h1122_3344, 32'hA1B2_C3D4, 1'b0, 4'h0, 32'h0, 32'h0000_00D4},
    '{3'd2, 32'h0000_0101, 32'h1122_3344, 32'hA1B2_C3D4, 1'b0, 4'h0, 32'h0, 32'h0000_00C3},
    '{3'd2, 32'h0000_0102, 32'h1122_3344, 32'hA1B2_C3D4, 1'b0, 4'h0, 32'h0, 32'h0000_00B2},
    '{3'd2, 32'h0000_0103, 32'h1122_3344, 32'hA1B2_C3D4, 1'b0, 4'h0, 32'h0, 32'h0000_00A1},
    '{3'd3, 32'h0000_0200, 32'h1122_3344, 32'hA1B2_C3D4, 1'b1, 4'hF, 32'h1122_3344, 32'h0},
    '{3'd4, 32'h0000_0200, 32'h1122_3344, 32'hA1B2_C3D4, 1'b1, 4'h1, 32'h4444_4444, 32'h0},
    '{3'd4, 32'h0000_0201, 32'h1122_3344, 32'hA1B2_C3D4, 1'b1, 4'h2, 32'h4444_4444, 32'h0},
    '{3'd4, 32'h0000_0202, 32'h1122_3344, 32'hA1B2_C3D4, 1'b1, 4'h4, 32'h4444_4444, 32'h0},
    '{3'd4, 32'h0000_0203, 32'hDEAD_BE9F, 32'hA1B2_C3D4, 1'b1, 4'h8, 32'h9F9F_9F9F, 32'h0},
    '{3'd0, 32'h0000_0203, 32'h1122_3344, 32'hA1B2_C3D4, 1'b0, 4'h0, 32'h0, 32'h0},
    '{3'd7, 32'h0000_0202, 32'h1122_3344, 32'hA1B2_C3D4, 1'b0, 4'h0, 32'h0, 32'h0},
    '{3'd1, 32'h0000_0103, 32'h1122_3344, 32'hA1B2_C3D4, 1'b0, 4'h0, 32'h0, 32'hA1B2_C3D4}
  };

  task automatic apply(input logic [2:0] k, input logic [31:0] a,
                       input logic [31:0] s, input logic [31:0] r);
    @(negedge clk);
    acc_kind = k; byte_addr = a; st_data = s; rd_word = r;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    acc_kind = 3'd0; byte_addr = '0; st_data = '0; rd_word = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // reset state: idle inputs give a silent port (R6, R9)
    check("R6 idle mem_we", {31'b0, mem_we}, 32'h0);
    check("R6 idle lane_we", {28'b0, lane_we}, 32'h0);
    check("R9 idle ld_result", ld_result, 32'h0);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].kind, TBL[i].addr, TBL[i].sd, TBL[i].rd);
      check($sformatf("R2 vec%0d mem_we", i), {31'b0, mem_we}, {31'b0, TBL[i].we});
      check($sformatf("R4 vec%0d lane_we", i), {28'b0, lane_we}, {28'b0, TBL[i].be});
      check($sformatf("R5 vec%0d wr_data", i), wr_data, TBL[i].wd);
      check($sformatf("R8 vec%0d ld_result", i), ld_result, TBL[i].ld);
      check($sformatf("R1 vec%0d word_addr", i), {2'b0, word_addr}, TBL[i].addr >> 2);
    end

    // R1 at the top of the address range
    apply(3'd1, 32'hFFFF_FFFF, 32'h0, 32'h0);
    check("R1 top word_addr", {2'b0, word_addr}, 32'h3FFF_FFFF);

    // R3 word store ignores offset bits
    apply(3'd3, 32'h0000_0402, 32'hCAFE_F00D, 32'h0);
    check("R3 sw off2 lane_we", {28'b0, lane_we}, 32'hF);
    check("R3 sw off2 wr_data", wr_data, 32'hCAFE_F00D);

    // sweep every code at every offset: R2 R6 R7 R9
    for (int k = 0; k < 8; k++) begin
      for (int o = 0; o < 4; o++) begin
        logic st, ld_w, ld_b;
        logic [31:0] exp_ld;
        apply(3'(k), 32'h0000_1000 + 32'(o), 32'h5A6B_7C8D, 32'h0102_0304);
        st   = (k == 3) || (k == 4);
        ld_w = (k == 1);
        ld_b = (k == 2);
        exp_ld = ld_w ? 32'h0102_0304 :
                 ld_b ? {24'b0, 8'(32'h0102_0304 >> (8 * o))} : 32'h0;
        check($sformatf("R2 k%0d o%0d mem_we", k, o), {31'b0, mem_we}, {31'b0, st});
        if (!st) check($sformatf("R6 k%0d o%0d wr_data", k, o), wr_data, 32'h0);
        if (!st) check($sformatf("R6 k%0d o%0d lane_we", k, o), {28'b0, lane_we}, 32'h0);
        if (ld_w) check($sformatf("R7 k%0d o%0d ld_result", k, o), ld_result, exp_ld);
        else      check($sformatf("R9 k%0d o%0d ld_result", k, o), ld_result, exp_ld);
      end
    end

    finish_run();
  end

endmodule